// File: doc/BRIEF.md
# Programmable Up-Counting Timer with PWM Channel

This block is a timer peripheral that sits on a simple register bus. The bus has a byte address, a 32-bit write data word, a write strobe and a read data word that follows the address combinationally. A clock divider turns the system clock into count ticks. A counter advances on each tick and returns to zero after it has reached a programmable limit. That return is the update event. It can raise a status flag and a one-cycle interrupt pulse, and it refreshes the working compare value of the pulse-width output on channel 2.

Software uses the block by setting the divider, the limit and the compare values, and then setting the run bit. It can also move the count: it can load the counter directly, force an update that clears it, or rewrite the divider without losing the current count. It clears the status flag by writing a word whose bit 0 is zero.

Top module: `upcount_timer`

## Requirements
- R1: After reset the run bit, interrupt enable, status flag, mode, channel enable, divider and counter all read zero. The limit register (0x2C) reads 0xFFFF. `irq_o` and `ch2_pwm_o` are low.
- R2: While the run bit (bit 0 at 0x00) is 1, the counter (0x24) increments once every divider+1 clock cycles, where the divider is held at 0x28. The first tick comes divider+1 cycles after the divider phase was restarted.
- R3: A tick that finds the counter greater than or equal to the limit (0x2C) sets the counter to zero instead of incrementing it. This is the update event.
- R4: An update event sets status bit 0 (0x10) and drives `irq_o` high for exactly one cycle, in the same cycle, only when interrupt-enable bit 0 (0x0C) is 1. When that bit is 0, the flag stays clear and no pulse appears.
- R5: A write to the status register ANDs write-data bit 0 into the flag. Writing 0 clears the flag, writing 1 leaves it unchanged, and software can never set it.
- R6: A write to 0x14 with bit 0 set zeroes the counter and the divider phase and copies the channel-2 compare value into the active compare. It does not set the flag. Register 0x14 always reads zero.
- R7: A divider write keeps only the low 16 bits of the data. It leaves the counter value unchanged and restarts the divider phase, so the new division applies from that write.
- R8: A counter write loads the low 16 bits as the new count and restarts the divider phase. Counting continues from the loaded value.
- R9: A limit write takes effect at once. The next tick compares the counter against the new limit.
- R10: While the run bit is 0, the counter and the divider phase hold, and no update event occurs.
- R11: Channel 2 is in pulse mode when mode bits [2:0] at 0x18 equal 110, preload bit 3 at 0x18 is 1, and enable bit 0 at 0x20 is 1. In pulse mode `ch2_pwm_o` is high while the counter is below the active compare and low otherwise. Outside pulse mode it is low.
- R12: A write to compare 2 (0x38) is held and reaches the active compare only at an update event, whether that event comes from a wrap or from the software update.
- R13: Compare 1 to 4 (0x34, 0x38, 0x3C, 0x40) read back their low 16 written bits. A write to any other unmapped offset changes no state, and a read of one returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wen_i | input | 1 | Write strobe, one write per cycle it is high |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | One-cycle update interrupt pulse |
| ch2_pwm_o | output | 1 | Channel-2 pulse-width output |

## Verification
The hardest case to reach from the ports is a compare-2 rewrite while the counter is running in pulse mode. The old active value must keep shaping the output until the wrap, and only then may the new value take over. The stimulus gets there with a short limit and a zero divider, so that wraps come every few cycles. It writes a new compare value in the middle of a period, and then again while a software update zeroes the counter. A behavioural model in the bench predicts the output and the interrupt line on every clock. A mistimed switch or a dropped pulse is therefore caught in the cycle where it happens.

// File: rtl/upt_pkg.sv
// Package: shared register offsets and field constants for the up-counting timer.
// Assumes byte addresses with 32-bit registers on 4-byte boundaries.
package upt_pkg;
    localparam int         REG_W        = 32;
    localparam int         NUM_CMP      = 4;
    localparam int         PWM_CH       = 1;      // index of channel 2
    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_IEN      = 8'h0C;
    localparam logic [7:0] OFS_STAT     = 8'h10;
    localparam logic [7:0] OFS_EVG      = 8'h14;
    localparam logic [7:0] OFS_CMODE    = 8'h18;
    localparam logic [7:0] OFS_CEN      = 8'h20;
    localparam logic [7:0] OFS_CNT      = 8'h24;
    localparam logic [7:0] OFS_DIV      = 8'h28;
    localparam logic [7:0] OFS_LIM      = 8'h2C;
    localparam logic [7:0] OFS_CMP_BASE = 8'h34;
    localparam logic [2:0] MODE_PULSE   = 3'b110;
endpackage

// File: rtl/upt_prescale.sv
// Clock divider: produces one tick every div_i+1 cycles while run_i is high.
// Assumes restart_i is high in the same cycle div_i changes, so the phase never exceeds div_i.
module upt_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    // Advance, wrap or restart the division phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart_i)
            phase_q <= '0;
        else if (run_i)
            phase_q <= (phase_q == div_i) ? '0 : phase_q + 1'b1;
    end

    assign tick_o = run_i && !restart_i && (phase_q == div_i);

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= div_i);

    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(phase_q));
endmodule

// File: rtl/upt_count.sv
// Up-counter with clear, load and wrap at a limit. Flags the wrap as the update event.
// Assumes tick_i is already low whenever clear_i or load_i is high.
module upt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && !clear_i && !load_i && (cnt_q >= limit_i);

    // Clear, load, wrap or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i)
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wrap_o && !clear_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/upt_pwm_ch.sv
// Pulse-width channel: holds the active compare, refreshed from the written value on update.
// Assumes update_i marks every update event, from a wrap or from software.
module upt_pwm_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] shadow_i,
    input  logic             update_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             out_o
);
    logic [CNT_W-1:0] active_q;

    // Take the pending compare value at each update event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (update_i)
            active_q <= shadow_i;
    end

    assign out_o = enable_i && (cnt_i < active_q);

    p_active_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> $stable(active_q));
endmodule

// File: rtl/upcount_timer.sv
// Top: register decode, status and interrupt logic around divider, counter and channel 2.
// Assumes one register write per cycle with wen_i and combinational reads on addr_i.
module upcount_timer
    import upt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              wen_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              ch2_pwm_o
);
    localparam int CMODE_W = 4;

    logic               run_q, uie_q, flag_q, ch2en_q, irq_q;
    logic [CMODE_W-1:0] cmode_q;
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   lim_q;
    logic [CNT_W-1:0]   cmp_q [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_hit;
    logic hit_ctrl, hit_ien, hit_stat, hit_evg, hit_cmode, hit_cen, hit_cnt, hit_div, hit_lim;
    logic hit_any, sw_upd, restart, tick, wrap, update_evt, pulse_en;
    logic [CNT_W-1:0] cnt;
    logic wdata_unused;

    assign wdata_unused = ^wdata_i;

    assign hit_ctrl  = addr_i == ADDR_W'(OFS_CTRL);
    assign hit_ien   = addr_i == ADDR_W'(OFS_IEN);
    assign hit_stat  = addr_i == ADDR_W'(OFS_STAT);
    assign hit_evg   = addr_i == ADDR_W'(OFS_EVG);
    assign hit_cmode = addr_i == ADDR_W'(OFS_CMODE);
    assign hit_cen   = addr_i == ADDR_W'(OFS_CEN);
    assign hit_cnt   = addr_i == ADDR_W'(OFS_CNT);
    assign hit_div   = addr_i == ADDR_W'(OFS_DIV);
    assign hit_lim   = addr_i == ADDR_W'(OFS_LIM);

    genvar k;
    generate
        for (k = 0; k < NUM_CMP; k++) begin : g_cmp
            assign cmp_hit[k] = addr_i == ADDR_W'(OFS_CMP_BASE + 8'(4 * k));

            // Hold the written compare value of channel k.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cmp_q[k] <= '0;
                else if (wen_i && cmp_hit[k])
                    cmp_q[k] <= wdata_i[CNT_W-1:0];
            end
        end
    endgenerate

    assign hit_any = hit_ctrl | hit_ien | hit_stat | hit_evg | hit_cmode | hit_cen
                   | hit_cnt | hit_div | hit_lim | (|cmp_hit);

    assign sw_upd     = wen_i && hit_evg && wdata_i[0];
    assign restart    = (wen_i && (hit_div || hit_cnt)) || sw_upd;
    assign update_evt = wrap || sw_upd;
    assign pulse_en   = (cmode_q[2:0] == MODE_PULSE) && cmode_q[3] && ch2en_q;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            uie_q   <= 1'b0;
            cmode_q <= '0;
            ch2en_q <= 1'b0;
            div_q   <= '0;
            lim_q   <= '1;
        end else if (wen_i) begin
            if (hit_ctrl)  run_q   <= wdata_i[0];
            if (hit_ien)   uie_q   <= wdata_i[0];
            if (hit_cmode) cmode_q <= wdata_i[CMODE_W-1:0];
            if (hit_cen)   ch2en_q <= wdata_i[0];
            if (hit_div)   div_q   <= wdata_i[DIV_W-1:0];
            if (hit_lim)   lim_q   <= wdata_i[CNT_W-1:0];
        end
    end

    // Status flag and interrupt pulse; a hardware set wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= wrap && uie_q && run_q;
            if (wrap && uie_q && run_q)
                flag_q <= 1'b1;
            else if (wen_i && hit_stat)
                flag_q <= flag_q & wdata_i[0];
        end
    end

    upt_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .run_i(run_q), .restart_i(restart),
        .div_i(div_q), .tick_o(tick)
    );

    upt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(sw_upd),
        .load_i(wen_i && hit_cnt), .load_val_i(wdata_i[CNT_W-1:0]),
        .limit_i(lim_q), .cnt_o(cnt), .wrap_o(wrap)
    );

    upt_pwm_ch #(.CNT_W(CNT_W)) u_ch2 (
        .clk(clk), .rst_n(rst_n), .shadow_i(cmp_q[PWM_CH]), .update_i(update_evt),
        .enable_i(pulse_en), .cnt_i(cnt), .out_o(ch2_pwm_o)
    );

    // Register read selection; unmapped offsets and the event register read zero.
    always_comb begin
        rdata_o = '0;
        if (hit_ctrl)       rdata_o[0] = run_q;
        else if (hit_ien)   rdata_o[0] = uie_q;
        else if (hit_stat)  rdata_o[0] = flag_q;
        else if (hit_cmode) rdata_o[CMODE_W-1:0] = cmode_q;
        else if (hit_cen)   rdata_o[0] = ch2en_q;
        else if (hit_cnt)   rdata_o[CNT_W-1:0] = cnt;
        else if (hit_div)   rdata_o[DIV_W-1:0] = div_q;
        else if (hit_lim)   rdata_o[CNT_W-1:0] = lim_q;
        for (int i = 0; i < NUM_CMP; i++)
            if (cmp_hit[i]) rdata_o[CNT_W-1:0] = cmp_q[i];
    end

    assign irq_o = irq_q;

    p_irq_with_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);

    p_flag_rise_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(run_q && uie_q));

    p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && hit_stat && !wrap) |=> (flag_q <= $past(flag_q)));

    p_div_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && hit_div) |=> $stable(cnt));

    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !restart) |=> ($stable(cnt) && !irq_o));

    p_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && !hit_any) |=> ($stable(run_q) && $stable(uie_q) && $stable(cmode_q)
                                 && $stable(ch2en_q) && $stable(div_q) && $stable(lim_q)));
endmodule

// File: tb/upcount_timer_bench.sv
// Bench: behavioural reference model updated each clock, outputs compared every cycle.
module upcount_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic        wen = 1'b0;
    logic [31:0] rdata;
    logic        irq, pwm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    upcount_timer u_upcount_timer (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wen_i(wen),
        .rdata_o(rdata), .irq_o(irq), .ch2_pwm_o(pwm)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int m_run, m_uie, m_flag, m_irq, m_cmode, m_cen, m_div, m_lim, m_cnt, m_phase, m_act;
    int m_cmp [4];
    int t_tick, t_wrap, t_swu, t_rph;

    // Model: one step per rising edge, from the bus values held across that edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_uie = 0; m_flag = 0; m_irq = 0; m_cmode = 0; m_cen = 0;
            m_div = 0; m_lim = 65535; m_cnt = 0; m_phase = 0; m_act = 0;
            for (int i = 0; i < 4; i++) m_cmp[i] = 0;
        end else begin
            t_swu  = (wen && addr == 8'h14 && wdata[0]) ? 1 : 0;
            t_rph  = (t_swu != 0 || (wen && (addr == 8'h28 || addr == 8'h24))) ? 1 : 0;
            t_tick = (m_run != 0 && t_rph == 0 && m_phase == m_div) ? 1 : 0;
            t_wrap = (t_tick != 0 && m_cnt >= m_lim) ? 1 : 0;
            m_irq  = (t_wrap != 0 && m_uie != 0) ? 1 : 0;
            if (m_irq != 0) m_flag = 1;
            else if (wen && addr == 8'h10) m_flag = m_flag & int'(wdata[0]);
            if (t_wrap != 0 || t_swu != 0) m_act = m_cmp[1];
            if (t_swu != 0) m_cnt = 0;
            else if (wen && addr == 8'h24) m_cnt = int'(wdata[15:0]);
            else if (t_tick != 0) m_cnt = (t_wrap != 0) ? 0 : m_cnt + 1;
            if (t_rph != 0) m_phase = 0;
            else if (m_run != 0) m_phase = (m_phase == m_div) ? 0 : m_phase + 1;
            if (wen) begin
                case (addr)
                    8'h00: m_run   = int'(wdata[0]);
                    8'h0C: m_uie   = int'(wdata[0]);
                    8'h18: m_cmode = int'(wdata[3:0]);
                    8'h20: m_cen   = int'(wdata[0]);
                    8'h28: m_div   = int'(wdata[15:0]);
                    8'h2C: m_lim   = int'(wdata[15:0]);
                    8'h34: m_cmp[0] = int'(wdata[15:0]);
                    8'h38: m_cmp[1] = int'(wdata[15:0]);
                    8'h3C: m_cmp[2] = int'(wdata[15:0]);
                    8'h40: m_cmp[3] = int'(wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_run;
            8'h0C: return m_uie;
            8'h10: return m_flag;
            8'h18: return m_cmode;
            8'h20: return m_cen;
            8'h24: return m_cnt;
            8'h28: return m_div;
            8'h2C: return m_lim;
            8'h34: return m_cmp[0];
            8'h38: return m_cmp[1];
            8'h3C: return m_cmp[2];
            8'h40: return m_cmp[3];
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of interrupt (R4) and pulse output (R11, R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 irq", int'(irq), m_irq);
            check("R11 R12 pwm", int'(pwm),
                  (m_cmode == 14 && m_cen != 0 && m_cnt < m_act) ? 1 : 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        addr = a;
        #1;
        check(req, int'(rdata), model_read(a));
    endtask

    task automatic rd_exp(input logic [7:0] a, input int exp, input string req);
        addr = a;
        #1;
        check(req, int'(rdata), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end

    initial begin : stimulus
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_exp(8'h2C, 32'hFFFF, "R1 limit");
        rd_exp(8'h24, 0, "R1 counter");
        rd_exp(8'h10, 0, "R1 status");
        rd_exp(8'h00, 0, "R1 run");
        check("R1 irq", int'(irq), 0);
        check("R1 pwm", int'(pwm), 0);

        // R2 division by 3, R3 wrap at 5, R4 interrupt enabled
        wr(8'h2C, 32'd5);
        wr(8'h28, 32'd2);
        wr(8'h0C, 32'd1);
        wr(8'h00, 32'd1);
        idle(3);
        rd_exp(8'h24, 1, "R2 first tick");
        idle(3);
        rd_exp(8'h24, 2, "R2 second tick");
        idle(30);
        rd(8'h24, "R3 counter");
        rd_exp(8'h10, 1, "R4 flag set");

        // R5 status AND-clear
        wr(8'h10, 32'd1);
        rd_exp(8'h10, 1, "R5 write one keeps");
        wr(8'h10, 32'd0);
        rd_exp(8'h10, 0, "R5 write zero clears");

        // R4 interrupt disabled: no flag across wraps
        wr(8'h0C, 32'd0);
        idle(40);
        rd_exp(8'h10, 0, "R4 no flag when disabled");
        wr(8'h10, 32'hFFFF_FFFF);
        rd_exp(8'h10, 0, "R5 no software set");

        // R6 software update
        wr(8'h14, 32'd1);
        rd_exp(8'h24, 0, "R6 counter zeroed");
        rd_exp(8'h14, 0, "R6 reads zero");
        rd_exp(8'h10, 0, "R6 no flag");

        // R7 divider write keeps count
        idle(7);
        rd(8'h24, "R7 before");
        wr(8'h28, 32'h0001_2341);
        rd_exp(8'h28, 32'h2341, "R7 low bits");
        rd(8'h24, "R7 counter kept");
        wr(8'h28, 32'd1);
        idle(5);
        rd(8'h24, "R7 new division");

        // R8 counter load, R9 limit write below count
        wr(8'h0C, 32'd1);
        wr(8'h24, 32'd4);
        rd_exp(8'h24, 4, "R8 loaded");
        wr(8'h2C, 32'd2);
        idle(2);
        rd_exp(8'h24, 0, "R9 immediate wrap");
        rd_exp(8'h10, 1, "R9 wrap is update");

        // R10 stopped
        wr(8'h00, 32'd0);
        rd(8'h24, "R10 stop");
        idle(20);
        rd(8'h24, "R10 held");
        wr(8'h10, 32'd0);

        // R11 and R12 pulse mode
        wr(8'h28, 32'd0);
        wr(8'h2C, 32'd9);
        wr(8'h18, 32'hE);
        wr(8'h20, 32'd1);
        wr(8'h38, 32'd4);
        rd_exp(8'h38, 4, "R12 compare readback");
        check("R12 not yet active", int'(pwm), 0);
        wr(8'h14, 32'd1);
        check("R11 high below compare", int'(pwm), 1);
        wr(8'h00, 32'd1);
        idle(6);
        wr(8'h38, 32'd7);
        idle(25);
        wr(8'h38, 32'd2);
        wr(8'h14, 32'd1);
        idle(15);
        wr(8'h18, 32'hF);
        idle(12);
        check("R11 mode 111 low", int'(pwm), 0);
        wr(8'h18, 32'h6);
        idle(12);
        check("R11 no preload low", int'(pwm), 0);

        // R13 compare registers and unmapped offsets
        wr(8'h34, 32'hABCD_1111);
        wr(8'h3C, 32'h3333);
        wr(8'h40, 32'h4444);
        rd_exp(8'h34, 32'h1111, "R13 compare 1");
        rd_exp(8'h3C, 32'h3333, "R13 compare 3");
        rd_exp(8'h40, 32'h4444, "R13 compare 4");
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd_exp(8'h30, 0, "R13 unmapped read");
        rd(8'h00, "R13 run unchanged");
        rd(8'h0C, "R13 ien unchanged");
        rd(8'h18, "R13 mode unchanged");
        rd(8'h28, "R13 divider unchanged");
        rd(8'h2C, "R13 limit unchanged");
        rd(8'h40, "R13 compare 4 unchanged");
        idle(3);
        finish_up();
    end
endmodule